// File: doc/BRIEF.md
# Serial Controller Status Flags and Interrupt Merge

This block keeps the eight status flags of a byte-oriented asynchronous serial controller and turns them into one interrupt request. It sits between the CPU register bus and the transmit/receive engine. The engine reports what happened with single-cycle strobes. The possible events are: the transmit buffer was handed to the shift register, a frame finished (data, or preamble/break), a received byte reached the readable data register, the line went idle, an overrun, noise, a framing error and a parity error. Each strobe sets its flag on the next clock edge.

Software clears flags only through a two-step sequence. A read of the status register arms the sequence. After that, a write to the data register clears the two transmit flags, and a read of the data register clears the receive and error flags. Any other register access in between disarms the sequence. The status register itself is read-only.

Per-event enable bits mask the flags. The masked flags are OR-ed into one interrupt line, and a global gate input qualifies that line. The block also tells the engine whether the transmit buffer holds data that may be moved into the shift register.

Top module: `uart_stat_irq`

## Requirements
- R1: After a synchronous active-low reset the status register reads 8'hC0 and the sequence is disarmed.
- R2: Status bit positions are 7 transmit-empty, 6 transmission-complete, 5 receive-ready, 4 idle, 3 overrun, 2 noise, 1 framing error and 0 parity error. Each event strobe sets its bit in the status register one clock after the strobe.
- R3: A transmit-load strobe sets bit 7. The output tx_buf_full equals the inverse of bit 7, and the engine may issue a transmit-load only while tx_buf_full is 1.
- R4: A frame-done strobe sets bit 6 only when ev_frame_data is 1 in the same cycle. A finished preamble or break frame (ev_frame_data 0) leaves bit 6 unchanged.
- R5: A status read (address 0, read) followed directly by a data write (address 1, write) clears bits 7 and 6. A data write that is not preceded by an armed status read leaves them set.
- R6: A status read followed directly by a data read clears bits 5 to 0 and leaves bits 7 and 6 unchanged.
- R7: Any bus access other than a status read disarms the sequence. This includes the data access that completes the sequence, a status write, and an access to addresses 2 or 3. Idle bus cycles keep the sequence armed.
- R8: A flag whose event strobe arrives in the same cycle as its clear stays set.
- R9: A write to the status address changes no flag.
- R10: The interrupt combines the flags through the enable vector ien as follows. ien[4] gates bit 7, ien[3] gates bit 6, ien[2] gates bit 5 OR bit 3, ien[1] gates bit 4, and ien[0] gates bit 0. The noise and framing flags never raise the interrupt.
- R11: irq is 0 whenever irq_gate is 0. The interrupt follows the flags and inputs combinationally, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register bus access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address: 0 status, 1 data, others foreign |
| ev_tx_load | input | 1 | Transmit buffer moved to shift register |
| ev_frame_done | input | 1 | A transmitted frame finished |
| ev_frame_data | input | 1 | The finished frame carried data (0 = preamble or break) |
| ev_rx_load | input | 1 | Received byte moved to readable data register |
| ev_idle | input | 1 | Idle line detected |
| ev_overrun | input | 1 | Receive overrun |
| ev_noise | input | 1 | Noise detected |
| ev_frame_err | input | 1 | Framing error |
| ev_parity | input | 1 | Parity error |
| ien | input | 5 | Per-event interrupt enables (see R10) |
| irq_gate | input | 1 | Global interrupt permission |
| stat_q | output | 8 | Status register contents |
| tx_buf_full | output | 1 | Transmit buffer holds data to be shifted |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle: the reset value, that each set strobe takes effect (including when a clear arrives in the same cycle), that preamble or break frames never set the complete flag, that status writes are ignored, that a flag falls only on a data access, and that the global gate blocks the interrupt. Only the bench's scenarios can show that the clear works as a sequence. This covers arming by a status read, disarming by intervening accesses, and the split of which flags a data write and a data read clear. The bench also shows the exact enable-to-flag mapping of the interrupt across all enable patterns.

// File: rtl/uart_stat_pkg.sv
// Package: shared constants for the serial status/interrupt block.
// Assumes an 8-bit status register and a 5-bit enable vector.
package uart_stat_pkg;

    localparam int STAT_W = 8;
    localparam int IEN_W  = 5;

    // Status bit positions (software decodes these)
    localparam int B_TXE   = 7;
    localparam int B_TXC   = 6;
    localparam int B_RXR   = 5;
    localparam int B_IDLE  = 4;
    localparam int B_OVR   = 3;
    localparam int B_NOISE = 2;
    localparam int B_FERR  = 1;
    localparam int B_PERR  = 0;

    localparam logic [STAT_W-1:0] STAT_RST = 8'hC0;
    localparam logic [STAT_W-1:0] TX_MASK  = 8'hC0;
    localparam logic [STAT_W-1:0] RX_MASK  = 8'h3F;

    // Enable vector positions
    localparam int E_TXE  = 4;
    localparam int E_TXC  = 3;
    localparam int E_RX   = 2;
    localparam int E_IDLE = 1;
    localparam int E_PERR = 0;

    // Decoded kind of a bus access
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STAT_RD,
        ACC_STAT_WR,
        ACC_DATA_RD,
        ACC_DATA_WR,
        ACC_FOREIGN
    } acc_kind_e;

endpackage

// File: rtl/uart_clr_seq.sv
// Module: decodes register bus accesses and runs the two-step clear
// sequence. A status read arms; any other access disarms. A data write
// while armed pulses clr_tx, a data read while armed pulses clr_rx.
// Assumes at most one access per cycle, qualified by acc_valid.
module uart_clr_seq
    import uart_stat_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              clr_tx,
    output logic              clr_rx
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

    acc_kind_e kind;
    logic      armed_q;

    // Classify the current bus access
    always_comb begin
        if (!acc_valid)
            kind = ACC_NONE;
        else if (acc_addr == A_STAT)
            kind = acc_write ? ACC_STAT_WR : ACC_STAT_RD;
        else if (acc_addr == A_DATA)
            kind = acc_write ? ACC_DATA_WR : ACC_DATA_RD;
        else
            kind = ACC_FOREIGN;
    end

    // Arm on status read, disarm on any other access, hold when idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (kind != ACC_NONE)
            armed_q <= (kind == ACC_STAT_RD);
    end

    // Clear pulses complete the sequence
    always_comb begin
        clr_tx = armed_q && (kind == ACC_DATA_WR);
        clr_rx = armed_q && (kind == ACC_DATA_RD);
    end

endmodule

// File: rtl/uart_flag_bank.sv
// Module: bank of sticky flags, one per status bit. Set wins over clear
// in the same cycle. Reset value per bit comes from RST_VAL.
module uart_flag_bank #(
    parameter int                 N       = 8,
    parameter logic [N-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] flag_q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag: reset value, set priority, then clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= RST_VAL[i];
            else if (set_v[i])
                flag_q[i] <= 1'b1;
            else if (clr_v[i])
                flag_q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_merge.sv
// Module: masks each interrupting flag with its enable and merges them
// into one request qualified by the global gate. Purely combinational.
// Noise and framing flags do not take part.
module uart_irq_merge
    import uart_stat_pkg::*;
(
    input  logic [STAT_W-1:0] flags,
    input  logic [IEN_W-1:0]  ien,
    input  logic              gate,
    output logic              irq
);

    logic [IEN_W-1:0] src;

    // Map flags to their enable slots
    always_comb begin
        src          = '0;
        src[E_TXE]   = flags[B_TXE];
        src[E_TXC]   = flags[B_TXC];
        src[E_RX]    = flags[B_RXR] | flags[B_OVR];
        src[E_IDLE]  = flags[B_IDLE];
        src[E_PERR]  = flags[B_PERR];
    end

    // Mask, merge and gate
    always_comb irq = gate & |(src & ien);

endmodule

// File: rtl/uart_stat_irq.sv
// Module: top of the status flag and interrupt block. Builds the set
// vector from engine strobes, the clear vector from the bus sequence,
// holds the flags, and drives the merged interrupt.
// Assumes strobes are single-cycle and synchronous to clk.
module uart_stat_irq
    import uart_stat_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              ev_tx_load,
    input  logic              ev_frame_done,
    input  logic              ev_frame_data,
    input  logic              ev_rx_load,
    input  logic              ev_idle,
    input  logic              ev_overrun,
    input  logic              ev_noise,
    input  logic              ev_frame_err,
    input  logic              ev_parity,
    input  logic [IEN_W-1:0]  ien,
    input  logic              irq_gate,
    output logic [STAT_W-1:0] stat_q,
    output logic              tx_buf_full,
    output logic              irq
);

    logic              clr_tx, clr_rx;
    logic [STAT_W-1:0] set_v, clr_v;

    uart_clr_seq #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_addr (acc_addr),
        .clr_tx   (clr_tx),
        .clr_rx   (clr_rx)
    );

    // Gather event strobes into the set vector
    always_comb begin
        set_v          = '0;
        set_v[B_TXE]   = ev_tx_load;
        set_v[B_TXC]   = ev_frame_done & ev_frame_data;
        set_v[B_RXR]   = ev_rx_load;
        set_v[B_IDLE]  = ev_idle;
        set_v[B_OVR]   = ev_overrun;
        set_v[B_NOISE] = ev_noise;
        set_v[B_FERR]  = ev_frame_err;
        set_v[B_PERR]  = ev_parity;
    end

    // Expand sequence pulses into per-flag clears
    always_comb clr_v = ({STAT_W{clr_tx}} & TX_MASK) | ({STAT_W{clr_rx}} & RX_MASK);

    uart_flag_bank #(
        .N      (STAT_W),
        .RST_VAL(STAT_RST)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (set_v),
        .clr_v (clr_v),
        .flag_q(stat_q)
    );

    uart_irq_merge u_irq (
        .flags(stat_q),
        .ien  (ien),
        .gate (irq_gate),
        .irq  (irq)
    );

    // Transmit buffer occupancy toward the engine
    always_comb tx_buf_full = ~stat_q[B_TXE];

endmodule

// File: rtl/uart_stat_irq_chk.sv
// Checker: temporal properties of the status/interrupt block, bound to
// the top. Observes ports only.
module uart_stat_irq_chk
    import uart_stat_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              ev_tx_load,
    input logic              ev_frame_done,
    input logic              ev_frame_data,
    input logic              ev_rx_load,
    input logic              ev_idle,
    input logic              ev_overrun,
    input logic              ev_noise,
    input logic              ev_frame_err,
    input logic              ev_parity,
    input logic [STAT_W-1:0] stat_q,
    input logic              tx_buf_full,
    input logic              irq_gate,
    input logic              irq
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

    logic any_ev;
    always_comb any_ev = ev_tx_load | ev_frame_done | ev_rx_load | ev_idle |
                         ev_overrun | ev_noise | ev_frame_err | ev_parity;

    AST_RESET_VALUE: assert property (@(posedge clk) !rst_n |=> stat_q == STAT_RST); // R1
    AST_RXR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_load |=> stat_q[B_RXR]); // R8
    AST_TXE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_load |=> stat_q[B_TXE]); // R3
    AST_TXLOAD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_load |-> tx_buf_full); // R3
    AST_NO_TXC_ON_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_done && !ev_frame_data && !stat_q[B_TXC]) |=> !stat_q[B_TXC]); // R4
    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == A_STAT && !any_ev) |=> $stable(stat_q)); // R9
    AST_RX_FALL_ON_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[B_RXR]) |-> $past(acc_valid && !acc_write && acc_addr == A_DATA)); // R6
    AST_TX_FALL_ON_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[B_TXC]) |-> $past(acc_valid && acc_write && acc_addr == A_DATA)); // R5
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_gate |-> !irq); // R11

endmodule

bind uart_stat_irq uart_stat_irq_chk #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .ev_tx_load   (ev_tx_load),
    .ev_frame_done(ev_frame_done),
    .ev_frame_data(ev_frame_data),
    .ev_rx_load   (ev_rx_load),
    .ev_idle      (ev_idle),
    .ev_overrun   (ev_overrun),
    .ev_noise     (ev_noise),
    .ev_frame_err (ev_frame_err),
    .ev_parity    (ev_parity),
    .stat_q       (stat_q),
    .tx_buf_full  (tx_buf_full),
    .irq_gate     (irq_gate),
    .irq          (irq)
);

// File: tb/sim_uart_stat_irq.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a flag model written from the requirements.
module sim_uart_stat_irq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0] acc_addr = 2'd0;
    logic       ev_tx_load = 0, ev_frame_done = 0, ev_frame_data = 0, ev_rx_load = 0;
    logic       ev_idle = 0, ev_overrun = 0, ev_noise = 0, ev_frame_err = 0, ev_parity = 0;
    logic [4:0] ien = 5'd0;
    logic       irq_gate = 1'b0;
    logic [7:0] stat_q;
    logic       tx_buf_full, irq;

    int   n_chk = 0, n_err = 0;
    bit   done = 0;
    logic [7:0] m_stat;
    logic       m_arm;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_stat_irq u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .ev_tx_load(ev_tx_load), .ev_frame_done(ev_frame_done),
        .ev_frame_data(ev_frame_data), .ev_rx_load(ev_rx_load), .ev_idle(ev_idle),
        .ev_overrun(ev_overrun), .ev_noise(ev_noise), .ev_frame_err(ev_frame_err),
        .ev_parity(ev_parity), .ien(ien), .irq_gate(irq_gate), .stat_q(stat_q),
        .tx_buf_full(tx_buf_full), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Interrupt expected from flags, enables and gate (R10, R11)
    function automatic logic f_irq(logic [7:0] s, logic [4:0] e, logic g);
        return g & ((s[7] & e[4]) | (s[6] & e[3]) | ((s[5] | s[3]) & e[2]) |
                    (s[4] & e[1]) | (s[0] & e[0]));
    endfunction

    // Next flags from the current model state and inputs
    function automatic logic [7:0] f_next(logic [7:0] s, logic arm);
        logic [7:0] setv, clrv;
        setv = {ev_tx_load, ev_frame_done & ev_frame_data, ev_rx_load, ev_idle,
                ev_overrun, ev_noise, ev_frame_err, ev_parity};
        clrv = 8'h00;
        if (acc_valid && acc_addr == 2'd1 && arm) clrv = acc_write ? 8'hC0 : 8'h3F;
        return setv | (s & ~clrv);
    endfunction

    task automatic clear_in();
        acc_valid = 0; acc_write = 0; acc_addr = 0;
        {ev_tx_load, ev_frame_done, ev_frame_data, ev_rx_load, ev_idle,
         ev_overrun, ev_noise, ev_frame_err, ev_parity} = '0;
    endtask

    // One clock: advance model, sample after the edge, compare status
    task automatic tick(input string req);
        logic [7:0] nxt;
        logic       narm;
        nxt  = f_next(m_stat, m_arm);
        narm = acc_valid ? (!acc_write && acc_addr == 2'd0) : m_arm;
        @(posedge clk);
        @(negedge clk);
        m_stat = nxt;
        m_arm  = narm;
        chk(stat_q === m_stat, req, 32'(stat_q), 32'(m_stat));
        clear_in();
    endtask

    task automatic bus(input logic wr, input logic [1:0] a, input string req);
        acc_valid = 1; acc_write = wr; acc_addr = a;
        tick(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_stat = 8'hC0; m_arm = 0;
        @(negedge clk);
        // R1 reset value
        chk(stat_q === 8'hC0, "R1 reset", 32'(stat_q), 32'hC0);
        chk(tx_buf_full === 1'b0, "R3 buf empty after reset", 32'(tx_buf_full), 0);

        // R5 data write without arming leaves tx flags
        bus(1, 2'd1, "R5 unarmed write keeps C0");
        // R5 armed write clears tx flags
        bus(0, 2'd0, "R5 status read");
        bus(1, 2'd1, "R5 armed write clears");
        chk(stat_q === 8'h00, "R5 cleared value", 32'(stat_q), 0);
        chk(tx_buf_full === 1'b1, "R3 buffer full", 32'(tx_buf_full), 1);

        // R3 transmit load sets bit 7
        ev_tx_load = 1; tick("R3 load");
        chk(stat_q[7] === 1'b1 && tx_buf_full === 1'b0, "R3 txe set", 32'(stat_q), 32'h80);

        // R4 preamble/break does not set complete; data frame does
        ev_frame_done = 1; ev_frame_data = 0; tick("R4 break frame");
        chk(stat_q[6] === 1'b0, "R4 no complete on break", 32'(stat_q[6]), 0);
        ev_frame_done = 1; ev_frame_data = 1; tick("R4 data frame");
        chk(stat_q[6] === 1'b1, "R4 complete on data", 32'(stat_q[6]), 1);

        // R2 each receive-side strobe sets its own bit
        ev_rx_load = 1; tick("R2 rx ready bit 5");
        ev_idle = 1; tick("R2 idle bit 4");
        ev_overrun = 1; tick("R2 overrun bit 3");
        ev_noise = 1; tick("R2 noise bit 2");
        ev_frame_err = 1; tick("R2 framing bit 1");
        ev_parity = 1; tick("R2 parity bit 0");
        chk(stat_q === 8'hFF, "R2 all set", 32'(stat_q), 32'hFF);

        // R7 foreign access between status read and data read disarms
        bus(0, 2'd0, "R7 arm");
        bus(0, 2'd2, "R7 foreign access");
        bus(0, 2'd1, "R7 data read after disarm");
        chk(stat_q === 8'hFF, "R7 nothing cleared", 32'(stat_q), 32'hFF);
        // R7 status write disarms too
        bus(0, 2'd0, "R7 arm again");
        bus(1, 2'd0, "R9 status write ignored");
        bus(1, 2'd1, "R7 write after status write");
        chk(stat_q === 8'hFF, "R7 still set", 32'(stat_q), 32'hFF);
        // R7 idle bus cycles keep the sequence armed
        bus(0, 2'd0, "R7 arm with gap");
        tick("R7 idle gap");

        // R6 armed data read clears only bits 5..0
        bus(0, 2'd1, "R6 armed read");
        chk(stat_q === 8'hC0, "R6 rx flags cleared", 32'(stat_q), 32'hC0);

        // R8 strobe in same cycle as clear keeps flag
        ev_rx_load = 1; ev_parity = 1; tick("R8 setup");
        bus(0, 2'd0, "R8 arm");
        acc_valid = 1; acc_write = 0; acc_addr = 2'd1; ev_rx_load = 1;
        tick("R8 set beats clear");
        chk(stat_q === 8'hE0, "R8 rx ready kept, parity cleared", 32'(stat_q), 32'hE0);

        // R9 status write ignored with every flag pattern
        ev_idle = 1; ev_noise = 1; tick("R9 setup");
        bus(1, 2'd0, "R9 status write");
        chk(stat_q === 8'hF4, "R9 unchanged", 32'(stat_q), 32'hF4);

        // R10 interrupt mapping over every enable pattern, gate open
        irq_gate = 1;
        for (int e = 0; e < 32; e++) begin
            ien = 5'(e);
            #1;
            chk(irq === f_irq(m_stat, ien, 1'b1), "R10 enable map", 32'(irq),
                32'(f_irq(m_stat, ien, 1'b1)));
        end
        // R10 noise and framing alone never interrupt
        bus(0, 2'd0, "R10 arm");
        bus(1, 2'd1, "R10 clear tx");
        bus(0, 2'd0, "R10 arm");
        bus(0, 2'd1, "R10 clear rx");
        ev_noise = 1; ev_frame_err = 1; tick("R10 noise framing set");
        ien = 5'h1F; #1;
        chk(irq === 1'b0, "R10 noise framing silent", 32'(irq), 0);
        // R11 gate blocks
        ev_parity = 1; tick("R11 parity set");
        irq_gate = 0; #1;
        chk(irq === 1'b0, "R11 gate closed", 32'(irq), 0);
        irq_gate = 1; #1;
        chk(irq === 1'b1, "R11 gate open", 32'(irq), 1);

        // Random traffic (R2 R5 R6 R7 R8 R10 R11)
        for (int i = 0; i < 4000; i++) begin
            ev_tx_load    = !m_stat[7] && ($urandom % 4 == 0);
            ev_frame_done = ($urandom % 6 == 0);
            ev_frame_data = $urandom % 2;
            ev_rx_load    = ($urandom % 6 == 0);
            ev_idle       = ($urandom % 10 == 0);
            ev_overrun    = ($urandom % 12 == 0);
            ev_noise      = ($urandom % 12 == 0);
            ev_frame_err  = ($urandom % 12 == 0);
            ev_parity     = ($urandom % 12 == 0);
            acc_valid     = ($urandom % 3 != 0);
            acc_write     = $urandom % 2;
            acc_addr      = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'($urandom % 2);
            if ($urandom % 16 == 0) ien = 5'($urandom);
            irq_gate = ($urandom % 8 != 0);
            #1;
            chk(irq === f_irq(m_stat, ien, irq_gate), "R10 R11 random irq", 32'(irq),
                32'(f_irq(m_stat, ien, irq_gate)));
            chk(tx_buf_full === !m_stat[7], "R3 random buf", 32'(tx_buf_full),
                32'(!m_stat[7]));
            tick("R2 R8 random flags");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule